// File: doc/BRIEF.md
# Length-Prefixed Frame Receiver

This block recovers variable-length messages from a byte stream that has no fixed transfer boundaries. A message opens with a one-byte start marker, followed by a length field of four bytes in big-endian order and then the payload. The length value counts the whole message, the four length bytes included, so the payload is the length minus four. A marker can be switched off by parameter. In that case the receiver treats the next byte after a message as the first byte of a new length field.

While it hunts, the receiver drops every byte until the marker arrives, and this lets it regain alignment in the middle of a stream. It then collects the length and checks it against a lower bound of four and a configured maximum. Payload bytes go straight through to a byte stream. The first byte carries a start flag and the last byte carries an end flag. An out-of-range length raises a one-cycle error pulse and sends the receiver back to hunting. While payload is passing through, backpressure from the output goes directly to the input ready signal. The receiver behaves the same whether the bytes arrive back to back or with gaps between them.

Top module: `lpf_rx`

## Requirements
- R1: After reset, out_valid_o and err_o are 0 and in_ready_o is 1.
- R2: While hunting, every byte that is not the marker value (0xA5 by default) is accepted and dropped, with out_valid_o held at 0.
- R3: The four bytes after the marker form the length, with the first byte as the most significant. For a length L with 5 <= L <= MAX_LEN, exactly L-4 payload bytes are passed out.
- R4: The first payload byte of a frame has out_sof_o=1 and the last has out_eof_o=1. A one-byte payload has both flags set. No other byte carries either flag.
- R5: During payload, out_data_o equals in_data_i and out_valid_o follows in_valid_i in the same cycle.
- R6: During payload, in_ready_o equals out_ready_i. A byte offered while out_ready_i is 0 stays unconsumed, and it keeps its flags until it is accepted.
- R7: A length below 4 or above MAX_LEN drives err_o high for exactly one cycle, the cycle after the last length byte is accepted. No payload follows, and the receiver returns to hunting.
- R8: A length of exactly 4 produces no output and no error, and the receiver returns to hunting.
- R9: Idle cycles (in_valid_i=0) between any two bytes do not change the output sequence, and out_valid_o is 0 during them.
- R10: A marker value inside the payload is passed out as data and does not restart framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_data_i | input | 8 | Input byte |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted when high with in_valid_i |
| out_data_o | output | 8 | Payload byte |
| out_valid_o | output | 1 | Payload byte valid |
| out_ready_i | input | 1 | Downstream accepts payload byte |
| out_sof_o | output | 1 | First payload byte of frame |
| out_eof_o | output | 1 | Last payload byte of frame |
| err_o | output | 1 | One-cycle pulse on out-of-range length |

## Verification
The bench builds the receiver with the marker enabled at 0xA5, a four-byte length and MAX_LEN set to 64. The small maximum brings both the exact upper boundary of 64 (60 payload bytes) and the first rejected value of 65 within a short run. With the marker enabled, the bench can also check that junk bytes are dropped between frames and after an error, and that a marker value inside a payload passes through as data.

// File: rtl/lpf_pkg.sv
package lpf_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_LEN  = 2'd1,
    ST_PAY  = 2'd2
  } lpf_state_e;
endpackage

// File: rtl/lpf_len_acc.sv
module lpf_len_acc #(
  parameter int LEN_BYTES = 4,
  localparam int LEN_W = 8 * LEN_BYTES,
  localparam int CNT_W = (LEN_BYTES > 1) ? $clog2(LEN_BYTES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [7:0]       data_i,
  output logic             done_o,
  output logic [LEN_W-1:0] value_o
);
  logic [CNT_W-1:0]   cnt_q;
  logic [LEN_W-9:0]   sr_q;

  assign done_o  = take_i && (cnt_q == CNT_W'(LEN_BYTES - 1));
  assign value_o = {sr_q, data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (take_i) begin
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
      sr_q  <= value_o[LEN_W-9:0];
    end
  end
endmodule

// File: rtl/lpf_pay_cnt.sv
module lpf_pay_cnt #(
  parameter int LEN_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] load_val_i,
  input  logic             step_i,
  output logic             first_o,
  output logic             last_o
);
  logic [LEN_W-1:0] rem_q;
  logic             first_q;

  assign first_o = first_q;
  assign last_o  = (rem_q == LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      first_q <= 1'b0;
    end else if (load_i) begin
      rem_q   <= load_val_i;
      first_q <= 1'b1;
    end else if (step_i) begin
      rem_q   <= rem_q - 1'b1;
      first_q <= 1'b0;
    end
  end

  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (rem_q != '0));
endmodule

// File: rtl/lpf_rx.sv
module lpf_rx
  import lpf_pkg::*;
#(
  parameter bit         MARKER_EN = 1'b1,
  parameter logic [7:0] MARKER    = 8'hA5,
  parameter int         LEN_BYTES = 4,
  parameter int         MAX_LEN   = 512,
  localparam int        LEN_W     = 8 * LEN_BYTES
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] in_data_i,
  input  logic       in_valid_i,
  output logic       in_ready_o,
  output logic [7:0] out_data_o,
  output logic       out_valid_o,
  input  logic       out_ready_i,
  output logic       out_sof_o,
  output logic       out_eof_o,
  output logic       err_o
);
  localparam lpf_state_e IDLE_ST = MARKER_EN ? ST_HUNT : ST_LEN;

  lpf_state_e       state_q, state_d;
  logic             hs_in, hs_out, len_take, len_done, len_bad, len_empty;
  logic             pay_first, pay_last, err_q;
  logic [LEN_W-1:0] len_val;

  assign in_ready_o  = (state_q == ST_PAY) ? out_ready_i : 1'b1;
  assign hs_in       = in_valid_i && in_ready_o;
  assign out_valid_o = (state_q == ST_PAY) && in_valid_i;
  assign out_data_o  = in_data_i;
  assign hs_out      = out_valid_o && out_ready_i;
  assign out_sof_o   = out_valid_o && pay_first;
  assign out_eof_o   = out_valid_o && pay_last;
  assign err_o       = err_q;

  assign len_take = hs_in && (state_q == ST_LEN);

  lpf_len_acc #(.LEN_BYTES(LEN_BYTES)) i_len_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (len_take),
    .data_i  (in_data_i),
    .done_o  (len_done),
    .value_o (len_val)
  );

  assign len_bad   = (len_val < LEN_W'(LEN_BYTES)) || (len_val > LEN_W'(MAX_LEN));
  assign len_empty = (len_val == LEN_W'(LEN_BYTES));

  lpf_pay_cnt #(.LEN_W(LEN_W)) i_pay_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (len_done && !len_bad && !len_empty),
    .load_val_i (len_val - LEN_W'(LEN_BYTES)),
    .step_i     (hs_out),
    .first_o    (pay_first),
    .last_o     (pay_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HUNT: if (hs_in && in_data_i == MARKER) state_d = ST_LEN;
      ST_LEN:  if (len_done) state_d = (len_bad || len_empty) ? IDLE_ST : ST_PAY;
      ST_PAY:  if (hs_out && pay_last) state_d = IDLE_ST;
      default: state_d = IDLE_ST;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= IDLE_ST;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= len_done && len_bad;
    end
  end

  assert_err_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  assert_no_out_on_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !out_valid_o);
  assert_stall_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !in_ready_o) |-> (out_valid_o && !out_ready_i));
  assert_eof_ends_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_out && out_eof_o) |=> !out_valid_o);
  assert_sof_once_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_out && out_sof_o && !out_eof_o) |=> !out_sof_o);
endmodule

// File: tb/test_lpf_rx.sv
module test_lpf_rx;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] in_data_i = '0;
  logic       in_valid_i = 1'b0;
  logic       in_ready_o;
  logic [7:0] out_data_o;
  logic       out_valid_o;
  logic       out_ready_i = 1'b1;
  logic       out_sof_o, out_eof_o, err_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  lpf_rx #(.MARKER_EN(1'b1), .MARKER(8'hA5), .LEN_BYTES(4), .MAX_LEN(64)) i_lpf_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_data_i(in_data_i), .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o), .out_data_o(out_data_o), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .out_sof_o(out_sof_o), .out_eof_o(out_eof_o), .err_o(err_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Offers one byte with out_ready_i=1; checks outputs before the edge, err after it.
  task automatic send_byte(input logic [7:0] b, input logic [3:0] f, input string req);
    in_data_i = b;
    in_valid_i = 1'b1;
    #1;
    chk(req, "out_valid", out_valid_o, f[3]);
    chk("R6", "in_ready", in_ready_o, 1);
    if (f[3]) begin
      chk("R5", "out_data", out_data_o, b);
      chk("R4", "sof", out_sof_o, f[2]);
      chk("R4", "eof", out_eof_o, f[1]);
    end
    @(posedge clk_i);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk(f[0] ? "R7" : req, "err", err_o, f[0]);
  endtask

  // {byte, valid, sof, eof, err-after}
  // F1 junk+len 7 (R2 R3 R10), F2 len 5 (R4), F3 len 4 (R8), F4 len 2 (R7),
  // junk after error (R2), F5 len 65 (R7), F6 len 6 (R3 R4)
  localparam int N_VEC = 39;
  localparam logic [11:0] VEC [N_VEC] = '{
    12'h110, 12'h220, 12'hA50, 12'h000, 12'h000, 12'h000, 12'h070, 12'h10C, 12'hA58, 12'h30A,
    12'hA50, 12'h000, 12'h000, 12'h000, 12'h050, 12'h5AE,
    12'hA50, 12'h000, 12'h000, 12'h000, 12'h040,
    12'hA50, 12'h000, 12'h000, 12'h000, 12'h021,
    12'h770,
    12'hA50, 12'h000, 12'h000, 12'h000, 12'h411,
    12'hA50, 12'h000, 12'h000, 12'h000, 12'h060, 12'h01C, 12'h02A
  };

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "out_valid", out_valid_o, 0);
    chk("R1", "err", err_o, 0);
    chk("R1", "in_ready", in_ready_o, 1);

    for (int i = 0; i < N_VEC; i++) begin
      send_byte(VEC[i][11:4], VEC[i][3:0], "R3");
      if (i % 5 == 4) begin // R9 idle gap
        @(posedge clk_i);
        @(negedge clk_i);
        chk("R9", "out_valid idle", out_valid_o, 0);
      end
    end

    // R6 backpressure: payload 2 bytes, first held for 3 cycles
    send_byte(8'hA5, 4'h0, "R6");
    send_byte(8'h00, 4'h0, "R6");
    send_byte(8'h00, 4'h0, "R6");
    send_byte(8'h00, 4'h0, "R6");
    send_byte(8'h06, 4'h0, "R6");
    out_ready_i = 1'b0;
    in_data_i = 8'hC1;
    in_valid_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R6", "in_ready stalled", in_ready_o, 0);
      chk("R6", "out_valid stalled", out_valid_o, 1);
      chk("R6", "sof held", out_sof_o, 1);
      @(negedge clk_i);
    end
    out_ready_i = 1'b1;
    send_byte(8'hC1, 4'hC, "R6");
    send_byte(8'hC2, 4'hA, "R6");

    // R7 upper boundary: length 64 accepted, 60 payload bytes
    send_byte(8'hA5, 4'h0, "R7");
    send_byte(8'h00, 4'h0, "R7");
    send_byte(8'h00, 4'h0, "R7");
    send_byte(8'h00, 4'h0, "R7");
    send_byte(8'h40, 4'h0, "R7");
    for (int j = 0; j < 60; j++)
      send_byte(8'(j + 8'h20), {1'b1, j == 0, j == 59, 1'b0}, "R3");
    send_byte(8'h99, 4'h0, "R2");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule